// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This unit turns a logical address issued by a user process into a physical address. It uses one relocation base and one bound. Every user-mode access is checked against the bound and offset by the base. An access beyond the bound, or a sum that does not fit the physical address width, returns a fault instead of an address. Accesses made in privileged mode skip relocation and reach any physical location.

The supervisor programs the pair one register at a time through a write port, or both at once through a restore port. Both paths take effect only in privileged mode. A user-mode attempt leaves the pair untouched and raises a protection flag. The current pair is always visible on the save outputs. A context switch therefore reads out the old pair, restores the new one, then drops to user mode. Responses are registered and appear one cycle after the request.

Top module: `reloc_unit`

## Requirements
- R1: After reset the save outputs show base 0 and bound 0, and `rsp_valid_o`, `rsp_fault_o` and `prot_err_o` are low.
- R2: A request with `req_valid_i` high gives `rsp_valid_o` high in the following cycle only. A cycle without a request gives `rsp_valid_o` low in the following cycle, and `rsp_fault_o` is never high without `rsp_valid_o`.
- R3: A user-mode (`priv_i`=0) request whose logical address does not exceed the bound returns base plus logical address with no fault.
- R4: A user-mode request whose logical address is greater than the bound returns fault high and address 0. An address equal to the bound is accepted, so a bound of 0 admits only logical address 0.
- R5: A user-mode request whose base plus logical address carries out of the PA_W-bit physical width returns fault high and address 0. A sum of exactly all-ones is accepted.
- R6: A privileged (`priv_i`=1) request returns the logical address zero-extended, with no fault, whatever the base and bound hold.
- R7: A privileged register write with `reg_sel_i`=0 loads the base from `reg_wdata_i`. With `reg_sel_i`=1 it loads the bound from the low LA_W bits. The new value shows on the save outputs the next cycle and governs requests from then on.
- R8: A register write or restore attempted with `priv_i`=0 leaves both registers unchanged and raises `prot_err_o` for exactly the next cycle.
- R9: A privileged restore loads base and bound together. When a restore and a register write arrive in the same cycle, the restore wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 1 | 1 = privileged mode, 0 = user mode |
| reg_wr_i | input | 1 | Single register write strobe |
| reg_sel_i | input | 1 | 0 = base, 1 = bound |
| reg_wdata_i | input | PA_W | Write data (bound uses low LA_W bits) |
| ctx_load_i | input | 1 | Restore strobe for the whole pair |
| ctx_base_i | input | PA_W | Base value to restore |
| ctx_limit_i | input | LA_W | Bound value to restore |
| ctx_base_o | output | PA_W | Current base, for saving |
| ctx_limit_o | output | LA_W | Current bound, for saving |
| prot_err_o | output | 1 | Rejected user-mode update, one-cycle pulse |
| req_valid_i | input | 1 | Access request strobe |
| req_laddr_i | input | LA_W | Logical address |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_paddr_o | output | PA_W | Physical address (0 on fault) |
| rsp_fault_o | output | 1 | Access fault |

## Verification
The bench uses the default widths: a 16-bit logical address and a 20-bit physical address. With a 20-bit base, a base near the top of the physical range plus a small offset carries out. This lets the bench drive the overflow fault and the exact all-ones sum next to each other. It also checks both sides of the bound, the zero bound, and privileged bypass of a bound that would otherwise fault. The narrow bound field lets the bench show that the top bits of a bound write are dropped.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_LIMIT = 1'b1
  } reg_sel_e;

  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_PRIV = 1'b1
  } mode_e;
endpackage

// File: rtl/reloc_regs.sv
module reloc_regs
  import reloc_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv,
  input  logic            wr,
  input  logic            sel,
  input  logic [PA_W-1:0] wdata,
  input  logic            ld,
  input  logic [PA_W-1:0] ld_base,
  input  logic [LA_W-1:0] ld_limit,
  output logic [PA_W-1:0] base,
  output logic [LA_W-1:0] limit,
  output logic            prot_err
);
  logic [PA_W-1:0] base_q, base_d;
  logic [LA_W-1:0] limit_q, limit_d;
  logic            err_q, err_d;
  logic            upd_en;
  mode_e           mode;

  assign mode = mode_e'(priv);

  // Next state: a restore takes priority over a single write.
  always_comb begin
    base_d  = base_q;
    limit_d = limit_q;
    err_d   = (wr || ld) && (mode == MODE_USER);
    upd_en  = 1'b0;
    if (mode == MODE_PRIV) begin
      if (ld) begin
        base_d  = ld_base;
        limit_d = ld_limit;
        upd_en  = 1'b1;
      end else if (wr) begin
        upd_en = 1'b1;
        if (reg_sel_e'(sel) == SEL_BASE) base_d = wdata;
        else                             limit_d = wdata[LA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (upd_en) begin
      base_q  <= base_d;
      limit_q <= limit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign base     = base_q;
  assign limit    = limit_q;
  assign prot_err = err_q;

  // R8
  user_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr || ld) && !priv) |=> ($stable(base_q) && $stable(limit_q)));

  // R8
  rej_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr || ld) && !priv) |=> prot_err);

  // R8
  no_false_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((wr || ld) && !priv) |=> !prot_err);

  // R9
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && priv) |=> (base == $past(ld_base) && limit == $past(ld_limit)));
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate
  import reloc_pkg::*;
#(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv,
  input  logic            req_valid,
  input  logic [LA_W-1:0] laddr,
  input  logic [PA_W-1:0] base,
  input  logic [LA_W-1:0] limit,
  output logic            rsp_valid,
  output logic [PA_W-1:0] paddr,
  output logic            fault
);
  localparam int SUM_W = PA_W + 1;

  logic [PA_W-1:0]  la_ext;
  logic [SUM_W-1:0] sum;
  logic             over_lim, carry;
  logic [PA_W-1:0]  paddr_q, paddr_d;
  logic             fault_q, fault_d;
  logic             vld_q;

  assign la_ext   = PA_W'(laddr);
  assign sum      = SUM_W'(base) + SUM_W'(laddr);
  assign over_lim = laddr > limit;
  assign carry    = sum[PA_W];

  always_comb begin
    paddr_d = paddr_q;
    fault_d = 1'b0;
    if (req_valid) begin
      if (mode_e'(priv) == MODE_PRIV) begin
        paddr_d = la_ext;
      end else if (over_lim || carry) begin
        paddr_d = '0;
        fault_d = 1'b1;
      end else begin
        paddr_d = sum[PA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         paddr_q <= '0;
    else if (req_valid) paddr_q <= paddr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      fault_q <= fault_d;
      vld_q   <= req_valid;
    end
  end

  assign rsp_valid = vld_q;
  assign paddr     = paddr_q;
  assign fault     = fault_q;

  // R2
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  fault_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> rsp_valid);

  // R6
  priv_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && priv) |=> (!fault && paddr == PA_W'($past(laddr))));

  // R4
  limit_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !priv && laddr > limit) |=> (fault && paddr == '0));
endmodule

// File: rtl/reloc_unit.sv
module reloc_unit #(
  parameter int LA_W = 16,
  parameter int PA_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv_i,
  input  logic            reg_wr_i,
  input  logic            reg_sel_i,
  input  logic [PA_W-1:0] reg_wdata_i,
  input  logic            ctx_load_i,
  input  logic [PA_W-1:0] ctx_base_i,
  input  logic [LA_W-1:0] ctx_limit_i,
  output logic [PA_W-1:0] ctx_base_o,
  output logic [LA_W-1:0] ctx_limit_o,
  output logic            prot_err_o,
  input  logic            req_valid_i,
  input  logic [LA_W-1:0] req_laddr_i,
  output logic            rsp_valid_o,
  output logic [PA_W-1:0] rsp_paddr_o,
  output logic            rsp_fault_o
);
  logic [PA_W-1:0] base_w;
  logic [LA_W-1:0] limit_w;

  reloc_regs #(.LA_W(LA_W), .PA_W(PA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .priv     (priv_i),
    .wr       (reg_wr_i),
    .sel      (reg_sel_i),
    .wdata    (reg_wdata_i),
    .ld       (ctx_load_i),
    .ld_base  (ctx_base_i),
    .ld_limit (ctx_limit_i),
    .base     (base_w),
    .limit    (limit_w),
    .prot_err (prot_err_o)
  );

  reloc_xlate #(.LA_W(LA_W), .PA_W(PA_W)) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .priv      (priv_i),
    .req_valid (req_valid_i),
    .laddr     (req_laddr_i),
    .base      (base_w),
    .limit     (limit_w),
    .rsp_valid (rsp_valid_o),
    .paddr     (rsp_paddr_o),
    .fault     (rsp_fault_o)
  );

  assign ctx_base_o  = base_w;
  assign ctx_limit_o = limit_w;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> (!rsp_fault_o && !prot_err_o));
endmodule

// File: tb/reloc_unit_test.sv
module reloc_unit_test;
  localparam int LA_W = 16;
  localparam int PA_W = 20;
  localparam int VW   = 1 + LA_W + PA_W + LA_W + PA_W + 1;
  localparam int NV   = 10;

  // {priv, laddr, base, limit, exp_paddr, exp_fault}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 16'h0240, 20'h04000, 16'h06FF, 20'h04240, 1'b0},  // R3
    {1'b0, 16'h06FF, 20'h04000, 16'h06FF, 20'h046FF, 1'b0},  // R4 equal
    {1'b0, 16'h0700, 20'h04000, 16'h06FF, 20'h00000, 1'b1},  // R4 over
    {1'b0, 16'h0000, 20'h03000, 16'h0FFF, 20'h03000, 1'b0},  // R3
    {1'b0, 16'h0010, 20'hFFFF0, 16'hFFFF, 20'h00000, 1'b1},  // R5 carry
    {1'b0, 16'h000F, 20'hFFFF0, 16'hFFFF, 20'hFFFFF, 1'b0},  // R5 edge
    {1'b1, 16'h1234, 20'h04000, 16'h0000, 20'h01234, 1'b0},  // R6
    {1'b1, 16'hFFFF, 20'hFFFF0, 16'h0000, 20'h0FFFF, 1'b0},  // R6
    {1'b0, 16'h0000, 20'h12345, 16'h0000, 20'h12345, 1'b0},  // R4 zero bound
    {1'b0, 16'hFFFF, 20'h00001, 16'hFFFF, 20'h10000, 1'b0}   // R3
  };

  logic            clk, rst_n, priv_i, reg_wr_i, reg_sel_i, ctx_load_i;
  logic [PA_W-1:0] reg_wdata_i, ctx_base_i, ctx_base_o, rsp_paddr_o;
  logic [LA_W-1:0] ctx_limit_i, ctx_limit_o, req_laddr_i;
  logic            prot_err_o, req_valid_i, rsp_valid_o, rsp_fault_o;

  int n_chk  = 0;
  int n_fail = 0;

  reloc_unit #(.LA_W(LA_W), .PA_W(PA_W)) uut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    priv_i = 1'b1; reg_wr_i = 1'b0; reg_sel_i = 1'b0; reg_wdata_i = '0;
    ctx_load_i = 1'b0; ctx_base_i = '0; ctx_limit_i = '0;
    req_valid_i = 1'b0; req_laddr_i = '0;
  endtask

  task automatic restore(input logic [PA_W-1:0] b, input logic [LA_W-1:0] l);
    @(negedge clk);
    idle();
    ctx_load_i = 1'b1; ctx_base_i = b; ctx_limit_i = l;
    @(negedge clk);
    idle();
  endtask

  initial begin : watchdog
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 base", 64'(ctx_base_o), 64'h0);
    check("R1 bound", 64'(ctx_limit_o), 64'h0);
    check("R1 flags", {61'h0, rsp_valid_o, rsp_fault_o, prot_err_o}, 64'h0);

    // R3 R4 R5 R6 table walk
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      restore(v[VW-1-1-LA_W -: PA_W], v[PA_W+1+LA_W-1 -: LA_W]);
      priv_i = v[VW-1]; req_valid_i = 1'b1; req_laddr_i = v[VW-2 -: LA_W];
      @(negedge clk);
      check($sformatf("R3/R4/R5/R6 vec%0d", i),
            {43'h0, rsp_valid_o, rsp_paddr_o},
            {43'h0, 1'b1, v[PA_W:1]});
      check($sformatf("R4/R5 fault vec%0d", i), 64'(rsp_fault_o), 64'(v[0]));
      idle();
      @(negedge clk);
      // R2
      check("R2 idle", {62'h0, rsp_valid_o, rsp_fault_o}, 64'h0);
    end

    // R7 single writes
    priv_i = 1'b1; reg_wr_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = 20'h0ABCD;
    @(negedge clk);
    check("R7 base", 64'(ctx_base_o), 64'h0ABCD);
    reg_sel_i = 1'b1; reg_wdata_i = 20'h12345;
    @(negedge clk);
    check("R7 bound", 64'(ctx_limit_o), 64'h2345);
    idle();
    priv_i = 1'b0; req_valid_i = 1'b1; req_laddr_i = 16'h0003;
    @(negedge clk);
    check("R7 used", 64'(rsp_paddr_o), 64'h0ABD0);

    // R8 rejected updates
    idle(); priv_i = 1'b0; reg_wr_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = 20'h11111;
    @(negedge clk);
    check("R8 flag", 64'(prot_err_o), 64'h1);
    check("R8 base", 64'(ctx_base_o), 64'h0ABCD);
    idle(); priv_i = 1'b0; ctx_load_i = 1'b1; ctx_base_i = 20'h22222; ctx_limit_i = 16'h0001;
    @(negedge clk);
    check("R8 restore flag", 64'(prot_err_o), 64'h1);
    check("R8 pair", {20'h0, ctx_base_o, 8'h0, ctx_limit_o}, {20'h0, 20'h0ABCD, 8'h0, 16'h2345});
    idle();
    @(negedge clk);
    check("R8 pulse ends", 64'(prot_err_o), 64'h0);

    // R9 restore beats write
    priv_i = 1'b1; ctx_load_i = 1'b1; ctx_base_i = 20'h50000; ctx_limit_i = 16'h0100;
    reg_wr_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = 20'h77777;
    @(negedge clk);
    check("R9 base", 64'(ctx_base_o), 64'h50000);
    check("R9 bound", 64'(ctx_limit_o), 64'h0100);
    check("R9 no flag", 64'(prot_err_o), 64'h0);
    idle();
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule